// File: doc/BRIEF.md
# Operating-Mode Clock Controller

This block chooses how the chip is clocked. It keeps one of four operating modes. In Slow, everything runs from the crystal oscillator. In Normal, everything runs from the main PLL. In Idle, the processor clock is halted. In Sleep, every clock is halted and the PLL is powered off. From the current mode it drives four things: the root clock source request to the glitch-free clock switch, the processor clock enable, a per-module clock enable vector, and the PLL power control.

Software acts on the block through a small write port. That port carries mode requests, a PLL reprogram strike and a module gating mask. A wake-up input ends Idle or Sleep. A PLL-ready level from the clock switch tells the controller when the PLL output can be used.

Moving onto the PLL, whether from Slow or by reprogramming it in Normal, keeps the root on the oscillator until ready is seen first low and then high again. All outputs are registered. A request applied in one cycle appears at the outputs two clock edges later.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A synchronous reset puts the controller into Slow. The mode status encoding is Slow=00, Normal=01, Idle=10, Sleep=11. After reset the module mask is all ones.
- R2: In Slow (with no PLL start pending), the outputs are:
  - `sel_pll`=0 and `cpu_clk_en`=1;
  - `mod_clk_en` equals the mask;
  - `pll_pwr_on`=0.
- R3: A Normal request made in Slow behaves as follows:
  - `pll_pwr_on` goes to 1 while the mode stays Slow and `sel_pll` stays 0;
  - the controller then waits until `pll_ready` has been seen low and afterwards high;
  - only then does it enter Normal, with `sel_pll`=1.
- R4: In Normal, `sel_pll`=1, `cpu_clk_en`=1, `mod_clk_en` equals the mask and `pll_pwr_on`=1. A Slow request from Normal returns to Slow with `sel_pll`=0 and `pll_pwr_on`=0.
- R5: A `pll_reprog` strike in Normal behaves as follows:
  - the mode stays Normal, `sel_pll` drops to 0 and `pll_pwr_on` stays 1;
  - `sel_pll` returns to 1 only after `pll_ready` has been seen low and then high.
- R6: An Idle request from Slow or Normal sets `cpu_clk_en`=0 and keeps `mod_clk_en` equal to the mask. `sel_pll` and `pll_pwr_on` keep the values of the mode Idle was entered from.
- R7: `wake` in Idle returns the controller to whichever of Slow or Normal it came from, with no PLL wait.
- R8: A Sleep request from Slow or Normal sets `cpu_clk_en`=0, `mod_clk_en`=0, `pll_pwr_on`=0 and `sel_pll`=0.
- R9: `wake` in Sleep always leads to Slow.
- R10: In Idle and Sleep the following inputs have no effect: mode requests, `pll_reprog` and mask writes.
- R11: In Slow and Normal, a `gate_wr` loads `gate_mask`. Bit i of `mod_clk_en` then follows bit i of the mask.
- R12: The following inputs are ignored:
  - `wake` while in Slow or Normal;
  - mode requests while a PLL lock wait is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode code |
| pll_reprog | input | 1 | PLL reprogram strike (Normal only) |
| gate_wr | input | 1 | Module mask write strobe |
| gate_mask | input | NMOD | New module mask |
| wake | input | 1 | Wake-up event |
| pll_ready | input | 1 | PLL output usable, from the clock switch |
| sel_pll | output | 1 | Root source request: 1 = PLL, 0 = oscillator |
| cpu_clk_en | output | 1 | Processor clock enable |
| mod_clk_en | output | NMOD | Per-module clock enables |
| pll_pwr_on | output | 1 | Main PLL power control |
| mode_o | output | 2 | Current mode status |

## Verification
The hardest states to reach are the pending windows. In these, power to the PLL is already on while the root is still the oscillator, and a stray request must be dropped there. The bench holds `pll_ready` low after each start or reprogram strike and samples the outputs in that window. It fires a competing mode request inside the window, and only then raises ready. Every combination of start mode (Slow, Normal) and requested mode is swept. Each Idle and Sleep stay is probed with ignored writes, and those writes are read back through `mod_clk_en` after wake.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_SLOW   = 2'b00,
    PM_NORMAL = 2'b01,
    PM_IDLE   = 2'b10,
    PM_SLEEP  = 2'b11
  } pm_mode_e;
endpackage

// File: rtl/pmc_lock_wait.sv
// Waits for the PLL-ready level to fall and then rise after a start.
module pmc_lock_wait (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic pll_ready,
  output logic busy,
  output logic done
);
  typedef enum logic [1:0] {LW_OFF, LW_DROP, LW_RISE} lw_e;
  lw_e st;

  always_ff @(posedge clk) begin
    if (rst) st <= LW_OFF;
    else begin
      case (st)
        LW_OFF:  if (start) st <= LW_DROP;
        LW_DROP: if (!pll_ready) st <= LW_RISE;
        LW_RISE: if (pll_ready) st <= LW_OFF;
        default: st <= LW_OFF;
      endcase
    end
  end

  assign busy = (st != LW_OFF);
  assign done = (st == LW_RISE) && pll_ready;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_valid,
  input  pm_mode_e req_mode,
  input  logic     pll_reprog,
  input  logic     wake,
  input  logic     lock_busy,
  input  logic     lock_done,
  output pm_mode_e mode,
  output pm_mode_e prev,
  output logic     lock_start
);
  pm_mode_e nxt, nprev;

  always_comb begin
    nxt        = mode;
    nprev      = prev;
    lock_start = 1'b0;
    case (mode)
      PM_SLOW: begin
        if (lock_done) nxt = PM_NORMAL;
        else if (!lock_busy && req_valid) begin
          case (req_mode)
            PM_NORMAL: lock_start = 1'b1;
            PM_IDLE:   begin nxt = PM_IDLE; nprev = PM_SLOW; end
            PM_SLEEP:  nxt = PM_SLEEP;
            default:   ;
          endcase
        end
      end
      PM_NORMAL: begin
        if (!lock_busy) begin
          if (req_valid && req_mode != PM_NORMAL) begin
            case (req_mode)
              PM_SLOW:  nxt = PM_SLOW;
              PM_IDLE:  begin nxt = PM_IDLE; nprev = PM_NORMAL; end
              PM_SLEEP: nxt = PM_SLEEP;
              default:  ;
            endcase
          end else if (pll_reprog) lock_start = 1'b1;
        end
      end
      PM_IDLE:  if (wake) nxt = prev;
      PM_SLEEP: if (wake) nxt = PM_SLOW;
      default:  nxt = PM_SLOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= PM_SLOW;
      prev <= PM_SLOW;
    end else begin
      mode <= nxt;
      prev <= nprev;
    end
  end
endmodule

// File: rtl/pmc_gate_reg.sv
module pmc_gate_reg #(
  parameter int NMOD = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic            allow,
  input  logic [NMOD-1:0] din,
  output logic [NMOD-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) mask <= '1;
    else if (wr && allow) mask <= din;
  end
endmodule

// File: rtl/pmc_out_stage.sv
module pmc_out_stage
  import pmc_pkg::*;
#(
  parameter int NMOD = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  pm_mode_e        mode,
  input  pm_mode_e        prev,
  input  logic            lock_busy,
  input  logic [NMOD-1:0] mask,
  output logic            sel_pll,
  output logic            cpu_clk_en,
  output logic [NMOD-1:0] mod_clk_en,
  output logic            pll_pwr_on,
  output logic [1:0]      mode_o
);
  logic            sel_d, cpu_d, pll_d;
  logic [NMOD-1:0] mod_d;

  always_comb begin
    sel_d = 1'b0;
    cpu_d = 1'b0;
    pll_d = 1'b0;
    mod_d = mask;
    case (mode)
      PM_SLOW:   begin cpu_d = 1'b1; pll_d = lock_busy; end
      PM_NORMAL: begin cpu_d = 1'b1; pll_d = 1'b1; sel_d = !lock_busy; end
      PM_IDLE:   begin sel_d = (prev == PM_NORMAL); pll_d = (prev == PM_NORMAL); end
      PM_SLEEP:  mod_d = '0;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_pll    <= 1'b0;
      cpu_clk_en <= 1'b1;
      mod_clk_en <= '1;
      pll_pwr_on <= 1'b0;
      mode_o     <= PM_SLOW;
    end else begin
      sel_pll    <= sel_d;
      cpu_clk_en <= cpu_d;
      mod_clk_en <= mod_d;
      pll_pwr_on <= pll_d;
      mode_o     <= mode;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NMOD = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_mode,
  input  logic            pll_reprog,
  input  logic            gate_wr,
  input  logic [NMOD-1:0] gate_mask,
  input  logic            wake,
  input  logic            pll_ready,
  output logic            sel_pll,
  output logic            cpu_clk_en,
  output logic [NMOD-1:0] mod_clk_en,
  output logic            pll_pwr_on,
  output logic [1:0]      mode_o
);
  pm_mode_e        mode, prev;
  logic            lock_start, lock_busy, lock_done;
  logic [NMOD-1:0] mask;
  logic            gate_allow;

  assign gate_allow = (mode == PM_SLOW) || (mode == PM_NORMAL);

  pmc_lock_wait u_lock (
    .clk(clk), .rst(rst), .start(lock_start), .pll_ready(pll_ready),
    .busy(lock_busy), .done(lock_done)
  );

  pmc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(pm_mode_e'(req_mode)),
    .pll_reprog(pll_reprog), .wake(wake), .lock_busy(lock_busy),
    .lock_done(lock_done), .mode(mode), .prev(prev), .lock_start(lock_start)
  );

  pmc_gate_reg #(.NMOD(NMOD)) u_gate (
    .clk(clk), .rst(rst), .wr(gate_wr), .allow(gate_allow),
    .din(gate_mask), .mask(mask)
  );

  pmc_out_stage #(.NMOD(NMOD)) u_out (
    .clk(clk), .rst(rst), .mode(mode), .prev(prev), .lock_busy(lock_busy),
    .mask(mask), .sel_pll(sel_pll), .cpu_clk_en(cpu_clk_en),
    .mod_clk_en(mod_clk_en), .pll_pwr_on(pll_pwr_on), .mode_o(mode_o)
  );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
  parameter int NMOD = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            pll_ready,
  input logic            sel_pll,
  input logic            cpu_clk_en,
  input logic [NMOD-1:0] mod_clk_en,
  input logic            pll_pwr_on,
  input logic [1:0]      mode_o
);
  // R1
  reset_slow_chk: assert property (@(posedge clk) rst |=> mode_o == 2'b00);

  // R8
  sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'b11 |-> (!cpu_clk_en && mod_clk_en == '0 && !pll_pwr_on));

  // R9
  sleep_exit_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == 2'b11 && mode_o != 2'b11) |-> mode_o == 2'b00);

  // R3
  pll_sel_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    sel_pll |-> pll_pwr_on);

  // R6
  idle_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    mode_o == 2'b10 |-> !cpu_clk_en);

  // R3
  lock_before_normal_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == 2'b00 && mode_o == 2'b01) |-> $past(pll_ready, 2));
endmodule

bind pwr_mode_ctrl pmc_chk #(.NMOD(NMOD)) u_chk (
  .clk(clk), .rst(rst), .pll_ready(pll_ready), .sel_pll(sel_pll),
  .cpu_clk_en(cpu_clk_en), .mod_clk_en(mod_clk_en),
  .pll_pwr_on(pll_pwr_on), .mode_o(mode_o)
);

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  localparam int NMOD = 4;
  localparam logic [1:0] S = 2'b00, N = 2'b01, I = 2'b10, Z = 2'b11;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, pll_reprog = 0, gate_wr = 0, wake = 0, pll_ready = 0;
  logic [1:0] req_mode = 0;
  logic [NMOD-1:0] gate_mask = 0;
  logic sel_pll, cpu_clk_en, pll_pwr_on;
  logic [NMOD-1:0] mod_clk_en;
  logic [1:0] mode_o;

  int checks = 0, errors = 0;
  logic [1:0] m_mode, m_prev;
  logic [NMOD-1:0] m_mask;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.NMOD(NMOD)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .pll_reprog(pll_reprog), .gate_wr(gate_wr), .gate_mask(gate_mask),
    .wake(wake), .pll_ready(pll_ready), .sel_pll(sel_pll),
    .cpu_clk_en(cpu_clk_en), .mod_clk_en(mod_clk_en),
    .pll_pwr_on(pll_pwr_on), .mode_o(mode_o)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic cmp(input string rq, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0h expected %0h", rq, nm, act, exp);
    end
  endtask

  // Expected outputs in a settled (non-pending) mode, from the model.
  task automatic check_all(input string rq);
    logic e_sel, e_cpu;
    logic [NMOD-1:0] e_mod;
    e_sel = (m_mode == N) || (m_mode == I && m_prev == N);
    e_cpu = (m_mode == S) || (m_mode == N);
    e_mod = (m_mode == Z) ? '0 : m_mask;
    cmp(rq, "mode", mode_o, m_mode);
    cmp(rq, "sel_pll", sel_pll, e_sel);
    cmp(rq, "cpu_clk_en", cpu_clk_en, e_cpu);
    cmp(rq, "mod_clk_en", mod_clk_en, e_mod);
    cmp(rq, "pll_pwr_on", pll_pwr_on, e_sel);
  endtask

  task automatic do_reset();
    rst = 1; pll_ready = 0; tick(3); rst = 0;
    m_mode = S; m_prev = S; m_mask = '1;
    tick(1);
  endtask

  task automatic req(input logic [1:0] m);
    req_valid = 1; req_mode = m; tick(1); req_valid = 0; tick(3);
  endtask

  task automatic lock_seq();
    pll_ready = 0; tick(2); pll_ready = 1; tick(3);
  endtask

  task automatic go_normal();
    req(N);
    // R3: pending, still Slow on the oscillator with PLL powered
    cmp("R3", "mode pending", mode_o, S);
    cmp("R3", "sel pending", sel_pll, 0);
    cmp("R3", "pwr pending", pll_pwr_on, 1);
    // R12: a request during the wait is dropped
    req(Z);
    cmp("R12", "mode pending after req", mode_o, S);
    lock_seq();
    m_mode = N;
    check_all("R3");
  endtask

  task automatic write_mask(input logic [NMOD-1:0] v);
    gate_wr = 1; gate_mask = v; tick(1); gate_wr = 0; tick(2);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run got stuck expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check_all("R1");
    check_all("R2");
    wake = 1; tick(1); wake = 0; tick(3);
    check_all("R12");

    // Sweep every start mode and requested mode
    for (int st = 0; st < 2; st++) begin
      for (int tg = 0; tg < 4; tg++) begin
        do_reset();
        if (st == 1) go_normal();
        if (tg == int'(N) && st == 0) begin
          go_normal();
        end else begin
          req(tg[1:0]);
          if (tg == int'(I)) begin m_prev = m_mode; m_mode = I; end
          else if (tg == int'(Z)) m_mode = Z;
          else if (tg == int'(S)) m_mode = S;
          if (tg == int'(S) && st == 1) pll_ready = 0;
          if (tg == int'(I)) check_all("R6");
          else if (tg == int'(Z)) check_all("R8");
          else check_all("R4");
          if (tg == int'(I) || tg == int'(Z)) begin
            write_mask(4'b0101);
            pll_reprog = 1; tick(1); pll_reprog = 0; tick(2);
            req(S);
            req(N);
            check_all("R10");
            if (tg == int'(Z)) pll_ready = 0;
            wake = 1; tick(1); wake = 0; tick(3);
            m_mode = (tg == int'(I)) ? m_prev : S;
            check_all(tg == int'(I) ? "R7" : "R9");
            cmp("R10", "mask after wake", mod_clk_en, 4'hF);
          end
        end
      end
    end

    // R11: mask sweep in Slow and Normal
    do_reset();
    for (int v = 0; v < 16; v++) begin
      write_mask(v[NMOD-1:0]); m_mask = v[NMOD-1:0];
      check_all("R11");
    end
    go_normal();
    for (int v = 15; v >= 0; v--) begin
      write_mask(v[NMOD-1:0]); m_mask = v[NMOD-1:0];
      check_all("R11");
    end

    // R12: wake in Normal has no effect
    wake = 1; tick(1); wake = 0; tick(3);
    check_all("R12");

    // R5: reprogram in Normal
    pll_reprog = 1; tick(1); pll_reprog = 0; tick(3);
    cmp("R5", "mode reprog", mode_o, N);
    cmp("R5", "sel reprog", sel_pll, 0);
    cmp("R5", "pwr reprog", pll_pwr_on, 1);
    req(S);
    cmp("R12", "mode reprog after req", mode_o, N);
    pll_ready = 0; tick(3);
    cmp("R5", "sel while low", sel_pll, 0);
    pll_ready = 1; tick(3);
    check_all("R5");

    // R4: back to Slow drops PLL power
    req(S); pll_ready = 0; m_mode = S;
    check_all("R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule